// File: doc/BRIEF.md
# Inter-processor signal controller

The controller carries doorbell signals between a local processor and a set of remote clients. Every signal has a 32-bit ID word that combines a client number and a signal number. Remote clients raise signals with single-cycle pulses. Each pulse is latched as a pending bit, and every signal has its own enable. The local processor reads one pending, enabled signal at a time from a receive register, in a fixed priority order. It clears that signal by writing the same ID to a clear register, and it keeps going until the read returns all ones. One active-high summary interrupt stays asserted while any enabled signal is pending.

Outbound, the processor writes an ID word to a send register. The controller then emits a one-cycle pulse on the line that belongs to that client and signal. A small state machine drives this pulse. It has two states: `TX_IDLE` (no pulse) and `TX_FIRE` (pulse on the held line). The transitions are:
- idle-to-fire on a valid send write;
- fire-to-fire on a back-to-back valid send write;
- fire-to-idle otherwise.

The client count and the signal count are parameters. Pulse lines are numbered client-major: line = client × NUM_SIGNALS + signal.

Top module: `ipsig_ctrl`

## Requirements
- R1: An ID word carries the client number in bits 31:16 and the signal number in bits 15:0. It maps to line client × NUM_SIGNALS + signal.
- R2: The register offsets are 0x0C send, 0x10 receive (read), 0x14 enable, 0x18 disable and 0x1C clear. Read data is combinational from the current state while `bus_rd` is high. A read at any offset other than 0x10, or with `bus_rd` low, returns zero.
- R3: A valid send write that is sampled at a clock edge drives exactly one `send_pulse` line, the addressed one, for the single following cycle. Consecutive send writes give consecutive pulses.
- R4: A `recv_pulse` bit sets the matching pending bit whether or not that signal is enabled. A disabled pending signal is invisible to the receive register and to `irq` until it is enabled.
- R5: A receive read returns the ID word of the pending, enabled signal with the lowest client number, and within that client the lowest signal number. It returns 0xFFFF_FFFF when none exists.
- R6: An enable or disable write affects only the one signal named by its ID word.
- R7: A clear write drops the named pending bit from the next cycle on, so that read-clear-read drains signals in priority order.
- R8: When an incoming pulse and a clear write hit the same signal in the same cycle, that signal stays pending.
- R9: `irq` is high exactly when at least one enabled signal is pending.
- R10: An ID word whose client is at or above NUM_CLIENTS, or whose signal is at or above NUM_SIGNALS, has no effect on any write register and gives no send pulse.
- R11: After reset all signals are disabled and not pending, `irq` is low and `send_pulse` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data (ID word) |
| bus_rdata | output | 32 | Read data |
| recv_pulse | input | NUM_CLIENTS*NUM_SIGNALS | Incoming signal pulses, client-major |
| send_pulse | output | NUM_CLIENTS*NUM_SIGNALS | Outgoing signal pulses, client-major |
| irq | output | 1 | Summary interrupt, level, active high |

## Verification
The assertions check on every cycle that:
- no incoming pulse is lost, even when a clear hits the same signal in that cycle;
- a clear without a coincident pulse takes effect;
- a valid send write is followed by a pulse, and no write means no pulse;
- an out-of-range send stays silent;
- `irq` agrees with what a receive read returns.

Other behaviours depend on the register sequence, so only the bench scenarios can show them. These are:
- the priority order during a full drain;
- the hiding and later release of signals latched while disabled;
- the specific aliasing cases where out-of-range IDs would truncate onto a real line.

// File: rtl/ipsig_pkg.sv
`timescale 1ns/1ps
package ipsig_pkg;
    localparam logic [7:0]  OFS_SEND = 8'h0C;
    localparam logic [7:0]  OFS_RECV = 8'h10;
    localparam logic [7:0]  OFS_ENA  = 8'h14;
    localparam logic [7:0]  OFS_DIS  = 8'h18;
    localparam logic [7:0]  OFS_CLR  = 8'h1C;
    localparam logic [31:0] NONE_PENDING = 32'hFFFF_FFFF;

    // R1: client in the upper half, signal in the lower half
    typedef struct packed {
        logic [15:0] client;
        logic [15:0] signal;
    } sig_id_t;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_FIRE = 1'b1
    } tx_state_t;
endpackage

// File: rtl/ipsig_decode.sv
`timescale 1ns/1ps
module ipsig_decode
    import ipsig_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    localparam int LINES = NUM_CLIENTS * NUM_SIGNALS,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  sig_id_t            id,
    output logic               ok,
    output logic [IDX_W-1:0]   idx,
    output logic [LINES-1:0]   mask
);
    // R10: both fields must be in range, compared at full width
    always_comb begin
        ok   = (32'(id.client) < NUM_CLIENTS) && (32'(id.signal) < NUM_SIGNALS);
        idx  = IDX_W'(32'(id.client) * NUM_SIGNALS + 32'(id.signal));
        mask = ok ? (LINES'(1) << idx) : '0;
    end
endmodule

// File: rtl/ipsig_pending.sv
`timescale 1ns/1ps
module ipsig_pending #(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    localparam int LINES = NUM_CLIENTS * NUM_SIGNALS,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] recv_pulse,
    input  logic [LINES-1:0] en_set,
    input  logic [LINES-1:0] en_clr,
    input  logic [LINES-1:0] pend_clr,
    output logic             hit_valid,
    output logic [IDX_W-1:0] hit_idx
);
    logic [LINES-1:0] pend;
    logic [LINES-1:0] en;

    // R4, R6, R7, R8: pulses win over clears; enables act per line
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
        end else begin
            en   <= (en | en_set) & ~en_clr;
            pend <= (pend & ~pend_clr) | recv_pulse;
        end
    end

    // R5: lowest line index wins (client-major numbering)
    always_comb begin
        hit_valid = 1'b0;
        hit_idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i] && en[i]) begin
                hit_valid = 1'b1;
                hit_idx   = IDX_W'(i);
            end
        end
    end

    a_r8_no_lost_event: assert property (@(posedge clk) disable iff (rst)
        (|recv_pulse) |=> ((pend & $past(recv_pulse)) == $past(recv_pulse)));

    a_r7_clear_takes_effect: assert property (@(posedge clk) disable iff (rst)
        (|(pend_clr & ~recv_pulse)) |=> ((pend & $past(pend_clr & ~recv_pulse)) == '0));
endmodule

// File: rtl/ipsig_sender.sv
`timescale 1ns/1ps
module ipsig_sender
    import ipsig_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    localparam int LINES = NUM_CLIENTS * NUM_SIGNALS,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [IDX_W-1:0] fire_idx,
    output logic [LINES-1:0] send_pulse
);
    tx_state_t        state, state_nx;
    logic [IDX_W-1:0] held_idx;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: state_nx = fire ? TX_FIRE : TX_IDLE;
            TX_FIRE: state_nx = fire ? TX_FIRE : TX_IDLE;
            default: state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            held_idx <= '0;
        end else begin
            state <= state_nx;
            if (fire) held_idx <= fire_idx;
        end
    end

    // R3: one line, one cycle
    always_comb begin
        unique case (state)
            TX_FIRE: send_pulse = LINES'(1) << held_idx;
            default: send_pulse = '0;
        endcase
    end

    a_r3_pulse_follows_fire: assert property (@(posedge clk) disable iff (rst)
        fire |=> (send_pulse != '0));

    a_r3_quiet_without_fire: assert property (@(posedge clk) disable iff (rst)
        !fire |=> (send_pulse == '0));
endmodule

// File: rtl/ipsig_ctrl.sv
`timescale 1ns/1ps
module ipsig_ctrl
    import ipsig_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGNALS = 8,
    parameter int ADDR_W      = 8,
    localparam int LINES = NUM_CLIENTS * NUM_SIGNALS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LINES-1:0]  recv_pulse,
    output logic [LINES-1:0]  send_pulse,
    output logic              irq
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    sig_id_t          wr_id;
    logic             id_ok;
    logic [IDX_W-1:0] id_idx;
    logic [LINES-1:0] id_mask;

    assign wr_id = sig_id_t'(bus_wdata);

    ipsig_decode #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_dec (
        .id   (wr_id),
        .ok   (id_ok),
        .idx  (id_idx),
        .mask (id_mask)
    );

    // R2: offset decode
    logic at_send, at_recv, at_ena, at_dis, at_clr;
    assign at_send = (bus_addr == ADDR_W'(OFS_SEND));
    assign at_recv = (bus_addr == ADDR_W'(OFS_RECV));
    assign at_ena  = (bus_addr == ADDR_W'(OFS_ENA));
    assign at_dis  = (bus_addr == ADDR_W'(OFS_DIS));
    assign at_clr  = (bus_addr == ADDR_W'(OFS_CLR));

    logic             fire;
    logic [LINES-1:0] en_set, en_clr, pend_clr;
    assign fire     = bus_wr && at_send && id_ok;
    assign en_set   = (bus_wr && at_ena) ? id_mask : '0;
    assign en_clr   = (bus_wr && at_dis) ? id_mask : '0;
    assign pend_clr = (bus_wr && at_clr) ? id_mask : '0;

    logic             hit_valid;
    logic [IDX_W-1:0] hit_idx;

    ipsig_pending #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .recv_pulse (recv_pulse),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .pend_clr   (pend_clr),
        .hit_valid  (hit_valid),
        .hit_idx    (hit_idx)
    );

    ipsig_sender #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .fire_idx   (id_idx),
        .send_pulse (send_pulse)
    );

    // R9: summary level
    assign irq = hit_valid;

    // R1, R5: rebuild the ID word of the winning line
    sig_id_t hit_id;
    always_comb begin
        hit_id.client = 16'(32'(hit_idx) / NUM_SIGNALS);
        hit_id.signal = 16'(32'(hit_idx) % NUM_SIGNALS);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && at_recv)
            bus_rdata = hit_valid ? 32'(hit_id) : NONE_PENDING;
    end

    a_r9_irq_matches_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && at_recv) |-> (irq == (bus_rdata != NONE_PENDING)));

    a_r10_bad_send_silent: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_send && !id_ok) |=> (send_pulse == '0));
endmodule

// File: tb/sim_ipsig_ctrl.sv
`timescale 1ns/1ps
module sim_ipsig_ctrl;
    localparam int NC = 4;
    localparam int NS = 8;
    localparam int N  = NC * NS;
    localparam logic [7:0] A_SEND = 8'h0C, A_RECV = 8'h10, A_ENA = 8'h14,
                           A_DIS = 8'h18, A_CLR = 8'h1C;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] recv = '0;
    logic [N-1:0] send;
    logic         irq;

    ipsig_ctrl #(.NUM_CLIENTS(NC), .NUM_SIGNALS(NS), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .recv_pulse(recv), .send_pulse(send), .irq(irq)
    );

    always #2 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R11";
    bit    pend_m[N];
    bit    en_m[N];
    int    send_exp = -1;
    bit    finished = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk_id(int c, int s);
        return {16'(c), 16'(s)};
    endfunction

    function automatic logic [31:0] model_recv();
        for (int i = 0; i < N; i++)
            if (pend_m[i] && en_m[i]) return mk_id(i / NS, i % NS);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit model_irq();
        for (int i = 0; i < N; i++)
            if (pend_m[i] && en_m[i]) return 1'b1;
        return 1'b0;
    endfunction

    // one clock: update the reference at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N; i++) begin pend_m[i] = 0; en_m[i] = 0; end
            send_exp = -1;
        end else begin
            int  c, s, k, nsend;
            bit  ok;
            c = int'(bus_wdata[31:16]);
            s = int'(bus_wdata[15:0]);
            ok = (c < NC) && (s < NS);
            k = c * NS + s;
            nsend = -1;
            if (bus_wr && ok) begin
                case (bus_addr)
                    A_SEND: nsend = k;
                    A_ENA:  en_m[k] = 1;
                    A_DIS:  en_m[k] = 0;
                    A_CLR:  pend_m[k] = 0;
                    default: ;
                endcase
            end
            for (int i = 0; i < N; i++) if (recv[i]) pend_m[i] = 1;
            send_exp = nsend;
        end
        @(negedge clk);
        begin
            logic [N-1:0] es;
            logic [31:0]  er;
            es = (send_exp >= 0) ? (N'(1) << send_exp) : '0;
            check(irq == model_irq(), {cur_req, " R9 irq"}, 32'(irq), 32'(model_irq()));
            check(send == es, {cur_req, " R3 send"}, send, es);
            if (bus_rd) begin
                er = (bus_addr == A_RECV) ? model_recv() : 32'h0;
                check(bus_rdata == er, {cur_req, " R5 rdata"}, bus_rdata, er);
            end
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_rd = 0;
    endtask

    task automatic pulse_line(int c, int s);
        recv = N'(1) << (c * NS + s);
        tick();
        recv = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] got[$];

        // R11: reset state
        cur_req = "R11";
        repeat (3) tick();
        check(irq == 1'b0, "R11 irq", 32'(irq), 32'h0);
        check(send == '0, "R11 send", send, 32'h0);
        rst = 0;
        tick();
        rd(A_RECV, d);
        check(d == 32'hFFFF_FFFF, "R11 nothing pending", d, 32'hFFFF_FFFF);

        // R4: latched while disabled, then released by enable (R6, R1)
        cur_req = "R4";
        pulse_line(1, 3);
        rd(A_RECV, d);
        check(d == 32'hFFFF_FFFF, "R4 disabled hidden", d, 32'hFFFF_FFFF);
        check(irq == 1'b0, "R4 irq low while disabled", 32'(irq), 32'h0);
        wr(A_ENA, mk_id(1, 3));
        rd(A_RECV, d);
        check(d == 32'h0001_0003, "R1 id format after enable", d, 32'h0001_0003);
        check(irq == 1'b1, "R9 irq high", 32'(irq), 32'h1);

        // R5 and R7: priority order and drain loop
        cur_req = "R5";
        wr(A_ENA, mk_id(2, 0));
        wr(A_ENA, mk_id(0, 7));
        wr(A_ENA, mk_id(0, 2));
        recv = (N'(1) << 16) | (N'(1) << 7) | (N'(1) << 2);
        tick();
        recv = '0;
        rd(A_RECV, d);
        check(d == mk_id(0, 2), "R5 lowest first", d, mk_id(0, 2));
        cur_req = "R7";
        for (int n = 0; n < 10; n++) begin
            rd(A_RECV, d);
            if (d == 32'hFFFF_FFFF) break;
            got.push_back(d);
            wr(A_CLR, d);
        end
        check(got.size() == 4, "R7 drain count", 32'(got.size()), 32'd4);
        if (got.size() == 4) begin
            check(got[0] == mk_id(0, 2), "R7 order 0", got[0], mk_id(0, 2));
            check(got[1] == mk_id(0, 7), "R7 order 1", got[1], mk_id(0, 7));
            check(got[2] == mk_id(1, 3), "R7 order 2", got[2], mk_id(1, 3));
            check(got[3] == mk_id(2, 0), "R7 order 3", got[3], mk_id(2, 0));
        end
        check(irq == 1'b0, "R9 irq low after drain", 32'(irq), 32'h0);

        // R8: pulse and clear on the same line in the same cycle
        cur_req = "R8";
        wr(A_ENA, mk_id(3, 5));
        pulse_line(3, 5);
        recv = N'(1) << 29;
        bus_wr = 1; bus_addr = A_CLR; bus_wdata = mk_id(3, 5);
        tick();
        recv = '0; bus_wr = 0;
        rd(A_RECV, d);
        check(d == mk_id(3, 5), "R8 event kept", d, mk_id(3, 5));
        wr(A_CLR, mk_id(3, 5));

        // R6: disable hides a single line, re-enable shows it again
        cur_req = "R6";
        wr(A_ENA, mk_id(2, 6));
        pulse_line(2, 6);
        wr(A_DIS, mk_id(2, 6));
        rd(A_RECV, d);
        check(d == 32'hFFFF_FFFF, "R6 disabled hidden", d, 32'hFFFF_FFFF);
        check(irq == 1'b0, "R6 irq low", 32'(irq), 32'h0);
        wr(A_ENA, mk_id(2, 6));
        rd(A_RECV, d);
        check(d == mk_id(2, 6), "R6 re-enabled", d, mk_id(2, 6));
        wr(A_CLR, mk_id(2, 6));

        // R3: send pulses, single and back-to-back
        cur_req = "R3";
        wr(A_SEND, mk_id(2, 4));
        check(send == (N'(1) << 20), "R3 single pulse", send, N'(1) << 20);
        tick();
        check(send == '0, "R3 pulse ends", send, 32'h0);
        wr(A_SEND, mk_id(0, 0));
        check(send == N'(1), "R3 first of pair", send, 32'h1);
        wr(A_SEND, mk_id(3, 7));
        check(send == (N'(1) << 31), "R3 second of pair", send, N'(1) << 31);
        tick();
        check(send == '0, "R3 pair ends", send, 32'h0);

        // R10: out-of-range IDs, including ones that would alias by truncation
        cur_req = "R10";
        wr(A_SEND, mk_id(4, 0));
        check(send == '0, "R10 bad client send", send, 32'h0);
        wr(A_SEND, mk_id(0, 8));
        check(send == '0, "R10 bad signal send", send, 32'h0);
        pulse_line(2, 1);
        pulse_line(0, 1);
        wr(A_ENA, mk_id(0, 17));
        wr(A_ENA, mk_id(4, 1));
        rd(A_RECV, d);
        check(d == 32'hFFFF_FFFF, "R10 bad enable", d, 32'hFFFF_FFFF);
        wr(A_ENA, mk_id(2, 1));
        wr(A_CLR, mk_id(6, 1));
        wr(A_DIS, mk_id(4, 17));
        wr(A_CLR, mk_id(16'h8002, 1));
        rd(A_RECV, d);
        check(d == mk_id(2, 1), "R10 bad clear and disable", d, mk_id(2, 1));
        wr(A_CLR, mk_id(2, 1));

        // R2: other offsets and idle read strobe
        cur_req = "R2";
        rd(8'h04, d);
        check(d == 32'h0, "R2 unmapped read", d, 32'h0);
        rd(A_SEND, d);
        check(d == 32'h0, "R2 send offset reads zero", d, 32'h0);
        #1 check(bus_rdata == 32'h0, "R2 no read strobe", bus_rdata, 32'h0);

        // mixed traffic compared against the reference every cycle
        cur_req = "R9 mixed";
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 7);
            recv = N'($urandom & $urandom & $urandom);
            bus_wr = 0; bus_rd = 0;
            bus_wdata = mk_id(int'($urandom % 5), int'($urandom % 9));
            case (op)
                0: begin bus_wr = 1; bus_addr = A_SEND; end
                1: begin bus_wr = 1; bus_addr = A_ENA; end
                2: begin bus_wr = 1; bus_addr = A_DIS; end
                3: begin bus_wr = 1; bus_addr = A_CLR; end
                4: begin bus_rd = 1; bus_addr = A_RECV; end
                5: begin bus_wr = 1; bus_addr = A_ENA; end
                default: begin bus_rd = 1; bus_addr = A_RECV; end
            endcase
            tick();
        end
        recv = '0; bus_wr = 0; bus_rd = 0;
        tick();

        finished = 1;
        summary();
        $finish;
    end
endmodule